// File: doc/BRIEF.md
# Card Insertion Debounce Timer

This block watches an asynchronous card-presence input and reports an insertion only after that input has stayed high, without interruption, for a programmable time. The input first passes through a two-flop synchronizer. While the synchronized level is high and the block is enabled, a prescale counter of `PRESCALE_W` bits counts down from all ones. Each time the prescaler runs out, it decrements an 8-bit hold counter. The hold counter is loaded from the stable-time register. When the hold counter's last tick arrives, the card-inserted status is raised. A bypass control makes every reference clock cycle a tick, which trades the long range for fine resolution.

Software programs the block through a small register port. The port has one write channel and one combinational read channel. The stable-time value sits at address 0 and the bypass control at address 1. Software clears the status with a clear pulse. Hardware clears it on a falling edge of the synchronized detect level. With the 16-bit default prescaler and a 100 MHz clock, the debounce span is about 0.66 ms per step. It runs from 0.66 ms at a value of 0 up to about 168 ms at 255.

Top module: `card_debounce`

## Requirements
- R1: After reset, both registers read 0 and `card_in_irq` is 0.
- R2: Address 0 holds the stable-time value N in data bits 7:0. Data bits 15:8 always read as zero.
- R3: Address 1 holds the bypass control in data bit 0. Data bits 15:1 always read as zero.
- R4: With bypass at 0, let K = (N+1) * 2^PRESCALE_W. The third clock edge after `detect_in` rises is counting cycle 1. `card_in_irq` reads 0 after edge K+1 and reads 1 after edge K+2, counted from the rise.
- R5: With bypass at 1, the same edge timing holds with K = N+1.
- R6: A low synchronized detect level during counting reloads both counters. The full period is then measured again from the next rise.
- R7: When the synchronized detect level falls, `card_in_irq` clears on the third clock edge after `detect_in` falls.
- R8: A pulse on `irq_clr` clears `card_in_irq` at the next edge. Once the status has been raised, counting stops. The status does not rise again until detect goes low and then high again. If a raise and a clear land on the same edge, the raise wins.
- R9: While `enable` is 0, both counters are held at their reload values and no raise occurs. From the first edge that samples `enable` high with detect high, `card_in_irq` rises at edge K.
- R10: The hold counter is loaded from the stable-time register only while it is reloading. A register write during counting leaves the current period unchanged and takes effect on the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows debounce counting |
| detect_in | input | 1 | Asynchronous card-presence level |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Write address (0 stable time, 1 control) |
| reg_wdata | input | DATA_W | Write data |
| reg_rd_addr | input | 1 | Read address |
| reg_rdata | output | DATA_W | Read data, combinational |
| irq_clr | input | 1 | Clears the card-inserted status |
| card_in_irq | output | 1 | Card-inserted status |

## Verification
The hardest conditions to reach from the ports involve the exact edge on which the status rises. One case is a detect level that drops partway through a long count. Another is a stable-time write landing mid-period. In both cases an off-by-one in the reload would shift the rise by just one cycle. The bench shrinks the prescaler to 4 bits so that whole periods fit in a short run. It then drives detect and the register port on falling clock edges at counted positions, and samples the status on the edge before and the edge of the expected rise. Random stable-time values and bypass settings are mixed with directed runs at 0 and 255.

// File: rtl/dbnc_pkg.sv
// Shared constants for the card insertion debounce timer.
// Assumes a one-bit register address space.
package dbnc_pkg;
    localparam logic ADDR_STABLE = 1'b0;   // stable-time value
    localparam logic ADDR_CTRL   = 1'b1;   // control, bit 0 = prescaler bypass
    localparam int   CTRL_BYPASS_BIT = 0;
endpackage

// File: rtl/dbnc_sync.sv
// Multi-stage synchronizer for the asynchronous detect input, plus a
// falling-edge pulse on the synchronized level.
// Assumes STAGES >= 2 and an input that may change at any time.
module dbnc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              level_q;

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= chain[STAGES-1];
    end

    assign level_o = chain[STAGES-1];
    assign fall_o  = level_q & ~chain[STAGES-1];
endmodule

// File: rtl/dbnc_regs.sv
// Register file: stable-time value and prescaler-bypass control.
// Assumes DATA_W > COUNT_W. Unused read bits return zero.
module dbnc_regs
    import dbnc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rd_addr,
    output logic [DATA_W-1:0]  rdata,
    output logic [COUNT_W-1:0] stable_o,
    output logic               bypass_o
);
    logic [COUNT_W-1:0] stable_q;
    logic               bypass_q;

    // Capture writes into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= '0;
            bypass_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_STABLE) stable_q <= wdata[COUNT_W-1:0];
            else                     bypass_q <= wdata[CTRL_BYPASS_BIT];
        end
    end

    // Form read data with unused bits forced to zero.
    always_comb begin
        rdata = '0;
        if (rd_addr == ADDR_STABLE) rdata[COUNT_W-1:0]     = stable_q;
        else                        rdata[CTRL_BYPASS_BIT] = bypass_q;
    end

    assign stable_o = stable_q;
    assign bypass_o = bypass_q;
endmodule

// File: rtl/dbnc_counter.sv
// Cascaded prescaler and hold counter. While run is low, both counters
// are held at their reload values. fire pulses on the cycle in which the
// last tick of the period occurs.
// Assumes PRESCALE_W >= 0; 0 means the prescaler is absent.
module dbnc_counter #(
    parameter int PRESCALE_W = 16,
    parameter int COUNT_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               bypass,
    input  logic [COUNT_W-1:0] load_val,
    output logic               fire
);
    logic               tick;
    logic [COUNT_W-1:0] hold_q;

    generate
        if (PRESCALE_W > 0) begin : g_pre
            logic [PRESCALE_W-1:0] pre_q;
            // Count the prescaler down from all ones, reloading when it
            // runs out or when counting is not active.
            always_ff @(posedge clk) begin
                if (!rst_n)                 pre_q <= '1;
                else if (!run || pre_q == '0) pre_q <= '1;
                else                        pre_q <= pre_q - 1'b1;
            end
            assign tick = bypass | (pre_q == '0);
        end else begin : g_nopre
            assign tick = 1'b1;
        end
    endgenerate

    // Reload the hold counter when idle; otherwise step it on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                           hold_q <= '0;
        else if (!run)                        hold_q <= load_val;
        else if (tick && hold_q != '0)        hold_q <= hold_q - 1'b1;
    end

    assign fire = run & tick & (hold_q == '0);
endmodule

// File: rtl/card_debounce.sv
// Card insertion debounce timer top. Synchronizes the detect input and
// runs the cascaded counter while detect is high and enable is set.
// Sets the status when the period completes. Clears the status on a
// detect fall or on irq_clr.
// Assumes one clock domain for everything except detect_in.
module card_debounce #(
    parameter int DATA_W     = 16,
    parameter int COUNT_W    = 8,
    parameter int PRESCALE_W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              detect_in,
    input  logic              reg_wr_en,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd_addr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              irq_clr,
    output logic              card_in_irq
);
    logic               det_s;
    logic               det_fall;
    logic [COUNT_W-1:0] stable_val;
    logic               bypass;
    logic               fire;
    logic               done_q;
    logic               run;

    dbnc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (detect_in),
        .level_o  (det_s),
        .fall_o   (det_fall)
    );

    dbnc_regs #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rd_addr  (reg_rd_addr),
        .rdata    (reg_rdata),
        .stable_o (stable_val),
        .bypass_o (bypass)
    );

    assign run = enable & det_s & ~done_q;

    dbnc_counter #(.PRESCALE_W(PRESCALE_W), .COUNT_W(COUNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .bypass   (bypass),
        .load_val (stable_val),
        .fire     (fire)
    );

    // Block further counting after a raise until detect drops.
    always_ff @(posedge clk) begin
        if (!rst_n)      done_q <= 1'b0;
        else if (!det_s) done_q <= 1'b0;
        else if (fire)   done_q <= 1'b1;
    end

    // Hold the card-inserted status; a raise wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   card_in_irq <= 1'b0;
        else if (fire)                card_in_irq <= 1'b1;
        else if (det_fall || irq_clr) card_in_irq <= 1'b0;
    end
endmodule

// File: rtl/card_debounce_chk.sv
// Property checker for card_debounce, attached with bind.
module card_debounce_chk
    import dbnc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int COUNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              det_s,
    input logic              det_fall,
    input logic              fire,
    input logic              irq_clr,
    input logic              card_in_irq,
    input logic              reg_rd_addr,
    input logic [DATA_W-1:0] reg_rdata
);
    p_stable_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_addr == ADDR_STABLE) |-> (reg_rdata[DATA_W-1:COUNT_W] == '0));

    p_ctrl_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_addr == ADDR_CTRL) |-> (reg_rdata[DATA_W-1:1] == '0));

    p_raise_needs_det_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_in_irq) |-> ($past(det_s) && $past(enable)));

    p_fall_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        det_fall |=> !card_in_irq);

    p_clear_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !fire) |=> !card_in_irq);

    p_single_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

bind card_debounce card_debounce_chk #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .det_s       (det_s),
    .det_fall    (det_fall),
    .fire        (fire),
    .irq_clr     (irq_clr),
    .card_in_irq (card_in_irq),
    .reg_rd_addr (reg_rd_addr),
    .reg_rdata   (reg_rdata)
);

// File: tb/test_card_debounce.sv
module test_card_debounce;
    localparam int DATA_W = 16;
    localparam int COUNT_W = 8;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic detect_in = 1'b0;
    logic reg_wr_en = 1'b0;
    logic reg_addr = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic reg_rd_addr = 1'b0;
    logic [DATA_W-1:0] reg_rdata;
    logic irq_clr = 1'b0;
    logic card_in_irq;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    card_debounce #(.DATA_W(DATA_W), .COUNT_W(COUNT_W), .PRESCALE_W(PW)) i_card_debounce (
        .clk(clk), .rst_n(rst_n), .enable(enable), .detect_in(detect_in),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata),
        .irq_clr(irq_clr), .card_in_irq(card_in_irq)
    );

    function automatic int period(int n, bit byp);
        return byp ? (n + 1) : ((n + 1) << PW);
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1 d = reg_rdata;
    endtask

    // Drop detect for a few cycles so both counters reload.
    task automatic drop();
        @(negedge clk); detect_in = 1'b0;
        edges(4);
    endtask

    // Raise detect and check the status on the edges around the rise.
    task automatic measure(input int n, input bit byp, input string req);
        int k = period(n, byp);
        @(negedge clk); detect_in = 1'b1;
        edges(k + 1);
        check(card_in_irq, 0, req);
        edges(1);
        check(card_in_irq, 1, req);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        int unsigned seed;
        seed = $urandom(32'h5eed);
        edges(3);
        #1 rst_n = 1'b1;
        // R1 reset state
        check(card_in_irq, 0, "R1");
        rd(1'b0, d); check(d, 0, "R1");
        rd(1'b1, d); check(d, 0, "R1");
        // R2 / R3 field widths
        wr(1'b0, 16'hFFFF); rd(1'b0, d); check(d, 16'h00FF, "R2");
        wr(1'b1, 16'hFFFF); rd(1'b1, d); check(d, 16'h0001, "R3");
        wr(1'b1, 16'hFFFE); rd(1'b1, d); check(d, 16'h0000, "R3");
        enable = 1'b1;

        // R5 directed: largest value in bypass, and zero in bypass
        wr(1'b1, 16'h1); wr(1'b0, 16'd255);
        measure(255, 1'b1, "R5");
        // R7: fall clears on third edge
        @(negedge clk); detect_in = 1'b0;
        edges(2); check(card_in_irq, 1, "R7");
        edges(1); check(card_in_irq, 0, "R7");
        edges(2);
        wr(1'b0, 16'd0);
        measure(0, 1'b1, "R5");
        drop();

        // R4 directed: zero value through the prescaler
        wr(1'b1, 16'h0);
        measure(0, 1'b0, "R4");
        drop();

        // Random mix for R4 and R5
        for (int i = 0; i < 14; i++) begin
            int n = $urandom_range(0, 63);
            bit b = 1'($urandom_range(0, 1));
            wr(1'b1, {15'b0, b});
            wr(1'b0, 16'(n));
            measure(n, b, b ? "R5" : "R4");
            drop();
            check(card_in_irq, 0, "R7");
        end

        // R6: interrupted count restarts
        begin
            int k;
            wr(1'b1, 16'h0); wr(1'b0, 16'd3);
            k = period(3, 1'b0);
            @(negedge clk); detect_in = 1'b1;
            edges(k / 2);
            @(negedge clk); detect_in = 1'b0;
            edges(3);
            check(card_in_irq, 0, "R6");
            measure(3, 1'b0, "R6");
        end

        // R8: software clear, no re-raise while held high
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check(card_in_irq, 0, "R8");
        edges(period(3, 1'b0) + 10);
        check(card_in_irq, 0, "R8");
        drop();
        measure(3, 1'b0, "R8");
        drop();

        // R9: disabled counting holds off the raise
        begin
            int k = period(1, 1'b0);
            wr(1'b0, 16'd1);
            @(negedge clk); enable = 1'b0; detect_in = 1'b1;
            edges(2 * k + 5);
            check(card_in_irq, 0, "R9");
            @(negedge clk); enable = 1'b1;
            edges(k - 1); check(card_in_irq, 0, "R9");
            edges(1);     check(card_in_irq, 1, "R9");
            drop();
        end

        // R10: mid-period write takes effect on the next period
        begin
            int k = period(2, 1'b0);
            wr(1'b0, 16'd2);
            @(negedge clk); detect_in = 1'b1;
            for (int i = 1; i <= k + 2; i++) begin
                if (i == 10) begin
                    reg_wr_en = 1'b1; reg_addr = 1'b0; reg_wdata = 16'd9;
                end
                @(posedge clk); #1;
                if (i == 10) reg_wr_en = 1'b0;
                if (i == k + 1) check(card_in_irq, 0, "R10");
                if (i == k + 2) check(card_in_irq, 1, "R10");
            end
            drop();
            measure(9, 1'b0, "R10");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule